// File: doc/BRIEF.md
# Data Access Translation and Fault Check

This block sits between a load/store pipeline and the data translation buffer. Each accepted request carries a virtual address plus a small set of qualifiers: store or load, physical, alternate-mode, table-walk and no-fault. The block decides the privilege mode that applies to the access. It takes one of four paths: physical pass-through, a kernel-only direct-mapped window, a canonical-address check, or a lookup in the translation buffer. The buffer's answer (hit, frame number, per-mode read/write enables and fault-on-read/write bits) arrives combinationally on the same cycle as the page number the block presents.

The result is a physical address and a fault code, returned one cycle after acceptance on a valid/ready response channel. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A response stalled by a low `rsp_ready` holds its payload and blocks new requests. A translation fault also loads three fault registers on the acceptance edge: the faulting address, a packed status word and a table-formatted address. Table-walk loads and no-fault (prefetch) accesses never disturb these registers.

Top module: `dxlate_chk`

## Requirements
- R1: Effective mode (0 kernel, 1 executive, 2 supervisor, 3 user) is `cur_mode` outside PAL mode. In PAL mode it is kernel, or `alt_mode` when `req_alt` is set. `req_alt` has no effect outside PAL mode.
- R2: With `req_phys` set, `rsp_pa` equals `req_va` and no translation check applies.
- R3: When bits 63:42 of the address are not all equal, a non-physical access gets fault code 2. Its status flags are bad-VA (bit 5) and access-violation (bit 1), plus write (bit 0) for stores.
- R4: With `sp_en` set and VA[42:41]=2, `rsp_pa` is VA[39:0] zero-extended, with no permission check. This requires `cur_mode` to be kernel; otherwise the fault code is 1 with flags access-violation plus write for stores.
- R5: `tlb_vpn` shows VA[42:13]. Outside R2 to R4, a miss gives fault code 4 for table-walk accesses and 3 otherwise, with miss flag bit 4 (plus write).
- R6: A store without the write enable for the effective mode gets code 2 with flags write and access-violation, plus fault-on-write (bit 3) if that bit is set. A permitted store with fault-on-write set gets code 2 with flags write and fault-on-write.
- R7: A load without the read enable gets code 1 with access-violation, plus fault-on-read (bit 2) if that bit is set. A permitted load with fault-on-read set gets code 2 with flag fault-on-read.
- R8: A hit forms the PA as the frame number shifted to bit 13, ORed with VA[12:0]. A fault-free result with any PA bit at 40 or above becomes code 5 (machine check), which loads no fault register. Code 0 means no fault.
- R9: A fault of code 1 to 4 loads `flt_va` with the address and `flt_stat` with {opcode[5:0], ra[4:0], flags[5:0]}. It loads `flt_form` with `pt_base` ORed with VA[42:13] shifted left by 3. Otherwise the three hold.
- R10: A table-walk or no-fault access never changes the three fault registers.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. The response appears on the edge after acceptance and is held unchanged while `rsp_ready` is low.
- R12: After reset `rsp_valid` is 0, `req_ready` is 1 and the fault registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | Store when 1 |
| req_phys | input | 1 | Physical access |
| req_alt | input | 1 | Use alternate mode in PAL mode |
| req_walk | input | 1 | Table-walk load |
| req_nofault | input | 1 | Prefetch, no fault latching |
| req_opcode | input | 6 | Opcode field for status |
| req_ra | input | 5 | Register field for status |
| pal_mode | input | 1 | PAL mode active |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode |
| sp_en | input | 1 | Direct window enable |
| pt_base | input | 64 | Table base for formatted address |
| tlb_vpn | output | 30 | Page number to look up |
| tlb_hit | input | 1 | Lookup hit |
| tlb_pfn | input | 31 | Frame number |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault on read |
| tlb_fonw | input | 1 | Fault on write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_pa | output | 64 | Physical address |
| rsp_fault | output | 3 | Fault code |
| flt_va | output | 64 | Latched faulting address |
| flt_stat | output | 17 | Latched status word |
| flt_form | output | 64 | Latched formatted address |

## Verification
The hardest case to reach is a suppressed fault: a fault that would latch the registers, issued as a no-fault or table-walk access. Its effect is only visible when the registers already hold a distinct, earlier fault. The vector table therefore orders rows so that each suppressed fault follows a latched fault with a different address and flags, and every row compares all three registers against a running model. A stalled-response sequence then changes the request inputs while `rsp_ready` is low, to show they are neither taken nor allowed to disturb the held response.

// File: rtl/dxlate_pkg.sv
package dxlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_ACV       = 3'd1,
    FLT_FAULT     = 3'd2,
    FLT_MISS      = 3'd3,
    FLT_WALK_MISS = 3'd4,
    FLT_MCHK      = 3'd5
  } xlt_fault_e;

  localparam int FLAG_W   = 6;
  localparam int FB_WR    = 0;
  localparam int FB_ACV   = 1;
  localparam int FB_FONR  = 2;
  localparam int FB_FONW  = 3;
  localparam int FB_MISS  = 4;
  localparam int FB_BADVA = 5;
endpackage

// File: rtl/dxlate_mode.sv
module dxlate_mode #(
  parameter int MODE_W = 2
) (
  input  logic              pal,
  input  logic              alt,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [MODE_W-1:0] eff_mode
);
  always_comb begin
    if (!pal)     eff_mode = cur_mode;
    else if (alt) eff_mode = alt_mode;
    else          eff_mode = '0;
  end
endmodule

// File: rtl/dxlate_perm.sv
module dxlate_perm
  import dxlate_pkg::*;
#(
  parameter int NMODE  = 4,
  parameter int MODE_W = $clog2(NMODE)
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              write,
  input  logic [NMODE-1:0]  rd_en,
  input  logic [NMODE-1:0]  wr_en,
  input  logic              fonr,
  input  logic              fonw,
  output xlt_fault_e        fault,
  output logic [FLAG_W-1:0] flags
);
  logic [NMODE-1:0] sel;
  logic allowed, fon;

  for (genvar m = 0; m < NMODE; m++) begin : g_sel
    assign sel[m] = (mode == MODE_W'(m));
  end

  assign allowed = write ? |(sel & wr_en) : |(sel & rd_en);
  assign fon     = write ? fonw : fonr;

  always_comb begin
    flags = '0;
    flags[FB_WR] = write;
    if (!allowed) begin
      fault = write ? FLT_FAULT : FLT_ACV;
      flags[FB_ACV] = 1'b1;
      if (fon) flags[write ? FB_FONW : FB_FONR] = 1'b1;
    end else if (fon) begin
      fault = FLT_FAULT;
      flags[write ? FB_FONW : FB_FONR] = 1'b1;
    end else begin
      fault = FLT_NONE;
    end
  end
endmodule

// File: rtl/dxlate_fregs.sv
module dxlate_fregs
  import dxlate_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int VPN_W = 30,
  parameter int OPC_W = 6,
  parameter int RA_W  = 5,
  localparam int STAT_W = OPC_W + RA_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [VA_W-1:0]   va,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [RA_W-1:0]   ra,
  input  logic [FLAG_W-1:0] flags,
  input  logic [VA_W-1:0]   pt_base,
  output logic [VA_W-1:0]   flt_va,
  output logic [STAT_W-1:0] flt_stat,
  output logic [VA_W-1:0]   flt_form
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_va   <= '0;
      flt_stat <= '0;
      flt_form <= '0;
    end else if (ld) begin
      flt_va   <= va;
      flt_stat <= {opcode, ra, flags};
      flt_form <= pt_base | (VA_W'(vpn) << 3);
    end
  end
endmodule

// File: rtl/dxlate_chk.sv
module dxlate_chk
  import dxlate_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_IMPL = 40,
  parameter int PG_BITS = 13,
  parameter int PFN_W   = 31,
  parameter int NMODE   = 4,
  parameter int OPC_W   = 6,
  parameter int RA_W    = 5,
  localparam int MODE_W = $clog2(NMODE),
  localparam int VPN_W  = VA_IMPL - PG_BITS,
  localparam int STAT_W = OPC_W + RA_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic              req_phys,
  input  logic              req_alt,
  input  logic              req_walk,
  input  logic              req_nofault,
  input  logic [OPC_W-1:0]  req_opcode,
  input  logic [RA_W-1:0]   req_ra,
  input  logic              pal_mode,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  input  logic              sp_en,
  input  logic [VA_W-1:0]   pt_base,
  output logic [VPN_W-1:0]  tlb_vpn,
  input  logic              tlb_hit,
  input  logic [PFN_W-1:0]  tlb_pfn,
  input  logic [NMODE-1:0]  tlb_rd_en,
  input  logic [NMODE-1:0]  tlb_wr_en,
  input  logic              tlb_fonr,
  input  logic              tlb_fonw,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_fault,
  output logic [VA_W-1:0]   flt_va,
  output logic [STAT_W-1:0] flt_stat,
  output logic [VA_W-1:0]   flt_form
);
  logic [MODE_W-1:0] eff_mode;
  xlt_fault_e        perm_flt, flt_c;
  logic [FLAG_W-1:0] perm_flg, flg_c;
  logic [VA_W-1:0]   pa_c, tlb_pa;
  logic              canon, sp_win, req_fire, latch;

  dxlate_mode #(.MODE_W(MODE_W)) u_mode (
    .pal(pal_mode), .alt(req_alt), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .eff_mode(eff_mode)
  );

  dxlate_perm #(.NMODE(NMODE), .MODE_W(MODE_W)) u_perm (
    .mode(eff_mode), .write(req_write), .rd_en(tlb_rd_en), .wr_en(tlb_wr_en),
    .fonr(tlb_fonr), .fonw(tlb_fonw), .fault(perm_flt), .flags(perm_flg)
  );

  assign tlb_vpn  = req_va[VA_IMPL-1:PG_BITS];
  assign canon    = (&req_va[VA_W-1:VA_IMPL-1]) | ~(|req_va[VA_W-1:VA_IMPL-1]);
  assign sp_win   = sp_en && (req_va[VA_IMPL-1:VA_IMPL-2] == 2'b10);
  assign tlb_pa   = (VA_W'(tlb_pfn) << PG_BITS) | VA_W'(req_va[PG_BITS-1:0]);
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_comb begin
    pa_c  = req_va;
    flt_c = FLT_NONE;
    flg_c = '0;
    flg_c[FB_WR] = req_write;
    if (!req_phys) begin
      if (!canon) begin
        flt_c = FLT_FAULT;
        flg_c[FB_ACV]   = 1'b1;
        flg_c[FB_BADVA] = 1'b1;
      end else if (sp_win) begin
        if (cur_mode != '0) begin
          flt_c = FLT_ACV;
          flg_c[FB_ACV] = 1'b1;
        end else begin
          pa_c = VA_W'(req_va[PA_IMPL-1:0]);
        end
      end else if (!tlb_hit) begin
        flt_c = req_walk ? FLT_WALK_MISS : FLT_MISS;
        flg_c[FB_MISS] = 1'b1;
      end else begin
        pa_c  = tlb_pa;
        flt_c = perm_flt;
        flg_c = perm_flg;
      end
    end
    if (flt_c == FLT_NONE && (|pa_c[VA_W-1:PA_IMPL])) flt_c = FLT_MCHK;
  end

  assign latch = req_fire && !req_walk && !req_nofault &&
                 (flt_c != FLT_NONE) && (flt_c != FLT_MCHK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= FLT_NONE;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_pa    <= pa_c;
      rsp_fault <= flt_c;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  dxlate_fregs #(.VA_W(VA_W), .VPN_W(VPN_W), .OPC_W(OPC_W), .RA_W(RA_W)) u_fregs (
    .clk(clk), .rst_n(rst_n), .ld(latch), .va(req_va), .vpn(tlb_vpn),
    .opcode(req_opcode), .ra(req_ra), .flags(flg_c), .pt_base(pt_base),
    .flt_va(flt_va), .flt_stat(flt_stat), .flt_form(flt_form)
  );

  AST_PHYS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_phys) |=> (rsp_pa == $past(req_va))); // R2
  AST_NO_WIDE_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_pa[VA_W-1:PA_IMPL] == '0)); // R8
  AST_QUIET_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && (req_walk || req_nofault)) |=>
      ($stable(flt_va) && $stable(flt_stat) && $stable(flt_form))); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault))); // R11
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R11
endmodule

// File: tb/sim_dxlate_chk.sv
module sim_dxlate_chk;
  typedef struct packed {
    logic [63:0] va;
    logic wr, phys, alt, walk, nf, pal;
    logic [1:0] cur, altm;
    logic sp, hit;
    logic [30:0] pfn;
    logic [3:0] rden, wren;
    logic fonr, fonw;
    logic [63:0] epa;
    logic [2:0] eflt;
    logic elat;
    logic [5:0] eflg;
  } vec_t;

  localparam logic [5:0]  OPC = 6'h29;
  localparam logic [4:0]  RAF = 5'h0C;
  localparam logic [63:0] PTB = 64'h0000_0004_0000_0000;
  localparam logic [63:0] SPVA = 64'hFFFF_FC12_3456_789A;
  localparam logic [63:0] HVA  = 64'h0000_0000_0040_2ABC;
  localparam logic [63:0] HPA  = 64'h0000_0000_2468_AABC;
  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{64'h0000_00AB_CDEF_0123, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0000_00AB_CDEF_0123, 3'd0, 1'b0, 6'h00}, // R2
    '{64'h0000_0100_0000_0000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0000_0100_0000_0000, 3'd5, 1'b0, 6'h00}, // R2 R8
    '{64'h0000_0800_0000_0000, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0, 3'd2, 1'b1, 6'h23}, // R3
    '{SPVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0000_0012_3456_789A, 3'd0, 1'b0, 6'h00}, // R4
    '{SPVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0, 3'd1, 1'b1, 6'h02}, // R4
    '{64'h0000_0000_0040_2000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0, 3'd3, 1'b1, 6'h10}, // R5
    '{64'h0000_0000_0080_4000, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0, 3'd4, 1'b0, 6'h00}, // R5 R10
    '{HVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h12345, 4'h1,4'h0, 1'b0,1'b0, HPA, 3'd0, 1'b0, 6'h00}, // R8
    '{HVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0,1'b1, 31'h12345, 4'h1,4'h0, 1'b1,1'b0, 64'h0, 3'd1, 1'b1, 6'h06}, // R7
    '{HVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h12345, 4'h1,4'h0, 1'b1,1'b0, 64'h0, 3'd2, 1'b1, 6'h04}, // R7
    '{HVA, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0,1'b1, 31'h12345, 4'h0,4'h1, 1'b0,1'b1, 64'h0, 3'd2, 1'b1, 6'h0B}, // R6
    '{64'h0000_0000_00C0_0010, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h12345, 4'h0,4'h1, 1'b0,1'b1, 64'h0, 3'd2, 1'b0, 6'h00}, // R6 R10
    '{HVA, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h12345, 4'h0,4'h1, 1'b0,1'b0, HPA, 3'd0, 1'b0, 6'h00}, // R6
    '{HVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd3,2'd0, 1'b0,1'b1, 31'h12345, 4'h1,4'h0, 1'b0,1'b0, HPA, 3'd0, 1'b0, 6'h00}, // R1
    '{HVA, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 2'd0,2'd3, 1'b0,1'b1, 31'h12345, 4'h1,4'h0, 1'b0,1'b0, 64'h0, 3'd1, 1'b1, 6'h02}, // R1
    '{HVA, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 2'd0,2'd3, 1'b0,1'b1, 31'h12345, 4'h8,4'h0, 1'b0,1'b0, HPA, 3'd0, 1'b0, 6'h00}, // R1
    '{HVA, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd3, 1'b0,1'b1, 31'h12345, 4'h1,4'h0, 1'b0,1'b0, HPA, 3'd0, 1'b0, 6'h00}, // R1
    '{HVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h4000_0000, 4'h1,4'h0, 1'b0,1'b0, 64'h0000_0800_0000_0ABC, 3'd5, 1'b0, 6'h00}, // R8
    '{SPVA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0, 3'd3, 1'b1, 6'h10}, // R4 R5
    '{SPVA, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0000_0012_3456_789A, 3'd0, 1'b0, 6'h00}, // R4
    '{SPVA, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b1,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 64'h0, 3'd1, 1'b1, 6'h03}  // R4
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0;
  logic req_write = 0, req_phys = 0, req_alt = 0, req_walk = 0, req_nofault = 0;
  logic pal_mode = 0, sp_en = 0, tlb_hit = 0, tlb_fonr = 0, tlb_fonw = 0, rsp_ready = 1;
  logic [1:0] cur_mode = '0, alt_mode = '0;
  logic [29:0] tlb_vpn;
  logic [30:0] tlb_pfn = '0;
  logic [3:0] tlb_rd_en = '0, tlb_wr_en = '0;
  logic rsp_valid;
  logic [63:0] rsp_pa, flt_va, flt_form;
  logic [2:0] rsp_fault;
  logic [16:0] flt_stat;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] m_va = '0, m_form = '0;
  logic [16:0] m_stat = '0;

  always #4 clk = ~clk;

  dxlate_chk u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_phys(req_phys), .req_alt(req_alt),
    .req_walk(req_walk), .req_nofault(req_nofault), .req_opcode(OPC), .req_ra(RAF),
    .pal_mode(pal_mode), .cur_mode(cur_mode), .alt_mode(alt_mode), .sp_en(sp_en),
    .pt_base(PTB), .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
    .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .flt_va(flt_va), .flt_stat(flt_stat), .flt_form(flt_form)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    req_va = v.va; req_write = v.wr; req_phys = v.phys; req_alt = v.alt;
    req_walk = v.walk; req_nofault = v.nf; pal_mode = v.pal; cur_mode = v.cur;
    alt_mode = v.altm; sp_en = v.sp; tlb_hit = v.hit; tlb_pfn = v.pfn;
    tlb_rd_en = v.rden; tlb_wr_en = v.wren; tlb_fonr = v.fonr; tlb_fonw = v.fonw;
  endtask

  task automatic check_regs(input string tag);
    chk(flt_va == m_va, tag, flt_va, m_va);
    chk(flt_stat == m_stat, tag, 64'(flt_stat), 64'(m_stat));
    chk(flt_form == m_form, tag, flt_form, m_form);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 1'b0, "R12 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R12 req_ready", 64'(req_ready), 64'd1);
    check_regs("R12 fault regs");

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      req_valid = 1'b1;
      #1;
      if (i == 7) chk(tlb_vpn == HVA[42:13], "R5 tlb_vpn", 64'(tlb_vpn), 64'(HVA[42:13]));
      @(negedge clk);
      if (TBL[i].elat) begin
        m_va = TBL[i].va;
        m_stat = {OPC, RAF, TBL[i].eflg};
        m_form = PTB | ({34'd0, TBL[i].va[42:13]} << 3);
      end
      chk(rsp_valid == 1'b1, $sformatf("R11 row %0d valid", i), 64'(rsp_valid), 64'd1);
      chk(rsp_fault == TBL[i].eflt, $sformatf("R1-8 row %0d fault", i), 64'(rsp_fault), 64'(TBL[i].eflt));
      if (TBL[i].eflt == 3'd0 || TBL[i].eflt == 3'd5)
        chk(rsp_pa == TBL[i].epa, $sformatf("R8 row %0d pa", i), rsp_pa, TBL[i].epa);
      check_regs($sformatf("R9 R10 row %0d regs", i));
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 drained", 64'(rsp_valid), 64'd0);

    // R11 back-pressure: response held, new request not taken
    rsp_ready = 1'b0;
    apply(TBL[7]);
    req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R11 stall ready", 64'(req_ready), 64'd0);
    chk(rsp_pa == HPA, "R11 stall pa", rsp_pa, HPA);
    apply(TBL[0]);
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b1, "R11 held valid", 64'(rsp_valid), 64'd1);
    chk(rsp_pa == HPA, "R11 held pa", rsp_pa, HPA);
    chk(rsp_fault == 3'd0, "R11 held fault", 64'(rsp_fault), 64'd0);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R11 ready on drain", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(rsp_pa == TBL[0].epa, "R11 next taken", rsp_pa, TBL[0].epa);
    req_valid = 1'b0;
    @(negedge clk);
    check_regs("R10 regs after stall");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule